// File: doc/BRIEF.md
# Flash Programming Controller with Key Unlock

This block sits between a processor's register bus and an embedded flash array and carries out the two destructive operations on that array: programming one word and erasing one page. Software prepares an operation in four registers (control, key, address, data). The block sends the command to the array only if software first arms it with an exact three-value key sequence and has already raised a write-enable bit. This guards against runaway code that writes to the controller by accident.

Each register can be written three ways: a direct write replaces the value, a set write ORs ones in, and a clear write removes the ones it names. A start request that arrives without a fresh unlock, with write enable low, aimed at a protected address window, or carrying an unknown operation code does not reach the array. It raises a sticky write-error flag instead. A low-voltage indication seen while the array is busy raises a second sticky flag. Software clears both flags by running a no-operation command through the same unlock flow.

The array side is a one-cycle request pulse plus a done pulse from the array. Operation code, address and data stay stable on the array outputs while the controller is busy.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the control, address and data registers read 0 and the array request is low.
- R2: A register write address is {index[1:0], alias[1:0]}. The index selects control=0, key=1, address=2, data=3. Alias 0 replaces the value, alias 1 ORs the write data in, alias 2 clears the bits set in the write data, and alias 3 has no effect. Reads through rd_sel return the register, and the key register always reads 0.
- R3: The key register counts as armed after three consecutive direct writes of 0x00000000, 0xAA996655 and 0x556699AA. A later direct or set write to control with bit 15 set, made while write enable (bit 14) is 1, then starts the operation. arr_req is high for exactly the one cycle after the start write. During that cycle arr_op holds the operation code from control bits 3:0 (1 = word write, 4 = page erase), arr_wdata holds the data register, and arr_addr holds the address.
- R4: A start request made while not armed, or with write enable low, sends no request and sets the write-error flag (control bit 13).
- R5: A key write with a wrong value or out of order returns the tracker to the unarmed state. Any non-key register write cancels the unlock, and a start request always uses it up.
- R6: The start bit (bit 15) reads 1 from the cycle after an accepted start until the cycle after arr_done is sampled high. Software cannot clear it.
- R7: While the start bit is 1, writes to the operation code field, the address register and the data register are ignored.
- R8: A word write or page erase whose effective address lies in the range PROT_LO..PROT_HI sets the write-error flag and sends no request.
- R9: low_volt sampled high in a cycle where the start bit is 1 sets the low-voltage flag (control bit 12).
- R10: An unlocked start with operation code 0 clears both error flags and sends no request. Software writes to bits 13 and 12 have no effect.
- R11: A page erase presents the address with its low PAGE_BITS bits forced to zero. A word write presents the full address.
- R12: An unlocked start with any operation code other than 0, 1 or 4 sets the write-error flag and sends no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | {register index, alias} for the write |
| reg_wdata | input | 32 | Register write data |
| rd_sel | input | 2 | Register index to read |
| rd_data | output | 32 | Read data for rd_sel |
| arr_req | output | 1 | One-cycle command pulse to the array |
| arr_op | output | 4 | Operation code presented to the array |
| arr_addr | output | ADDR_W | Effective array address |
| arr_wdata | output | DATA_W | Word to program |
| arr_done | input | 1 | Array completion pulse |
| low_volt | input | 1 | Supply low-voltage indication |

## Verification
The completion of an erase, a low-voltage sample and a register write to the address register can all fall in the same cycle. The bench provokes this by raising arr_done and low_volt in the same cycle as a direct address write, while a page erase is in progress. The expected result is that the start bit clears, the low-voltage flag is set, and the address keeps its pre-operation value, because the controller was still busy when the write arrived. A second collision, a key-armed start followed by a stray address write, checks that the unlock is cancelled rather than carried over.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_KEY  = 2'd1;
    localparam logic [1:0] IDX_ADDR = 2'd2;
    localparam logic [1:0] IDX_DATA = 2'd3;

    localparam logic [1:0] AL_DIRECT = 2'd0;
    localparam logic [1:0] AL_SET    = 2'd1;
    localparam logic [1:0] AL_CLEAR  = 2'd2;
    localparam logic [1:0] AL_NONE   = 2'd3;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_WORD  = 4'd1;
    localparam logic [3:0] OP_ERASE = 4'd4;

    localparam int B_START = 15;
    localparam int B_WREN  = 14;

    localparam logic [31:0] KEY_FIRST  = 32'h0000_0000;
    localparam logic [31:0] KEY_SECOND = 32'hAA99_6655;
    localparam logic [31:0] KEY_THIRD  = 32'h5566_99AA;

    typedef enum logic [1:0] {K_IDLE, K_ONE, K_TWO, K_ARMED} key_st_e;

    typedef struct packed {
        logic busy;
        logic wrerr;
        logic lverr;
        logic req;
    } seq_st_t;

endpackage

// File: rtl/nvm_key_tracker.sv
module nvm_key_tracker
    import nvm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr_i,
    input  logic [31:0] key_val_i,
    input  logic        other_wr_i,
    output logic        armed_o
);

    key_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr_i) begin
            if (key_val_i == KEY_FIRST)                         st_d = K_ONE;
            else if (st_q == K_ONE && key_val_i == KEY_SECOND)  st_d = K_TWO;
            else if (st_q == K_TWO && key_val_i == KEY_THIRD)   st_d = K_ARMED;
            else                                                st_d = K_IDLE;
        end else if (other_wr_i) begin
            st_d = K_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= K_IDLE;
        else        st_q <= st_d;
    end

    assign armed_o = (st_q == K_ARMED);

    // R5: arming only follows the final key value
    p_arm_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(key_wr_i && key_val_i == KEY_THIRD));

    // R5: any other write drops the unlock
    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr_i |=> !armed_o);

endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
    import nvm_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PROT_LO = 'hF000,
    parameter logic [ADDR_W-1:0] PROT_HI = 'hFEFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_try_i,
    input  logic              armed_i,
    input  logic              wren_i,
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] eff_addr_i,
    input  logic              arr_done_i,
    input  logic              low_volt_i,
    output logic              busy_o,
    output logic              wrerr_o,
    output logic              lverr_o,
    output logic              req_o
);

    seq_st_t d, q;
    logic    in_prot;

    assign in_prot = (eff_addr_i >= PROT_LO) && (eff_addr_i <= PROT_HI);

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (q.busy) begin
            if (low_volt_i) d.lverr = 1'b1;
            if (arr_done_i) d.busy  = 1'b0;
        end else if (start_try_i) begin
            if (!(armed_i && wren_i)) begin
                d.wrerr = 1'b1;
            end else begin
                case (op_i)
                    OP_NOP: begin
                        d.wrerr = 1'b0;
                        d.lverr = 1'b0;
                    end
                    OP_WORD, OP_ERASE: begin
                        if (in_prot) begin
                            d.wrerr = 1'b1;
                        end else begin
                            d.busy = 1'b1;
                            d.req  = 1'b1;
                        end
                    end
                    default: d.wrerr = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o  = q.busy;
    assign wrerr_o = q.wrerr;
    assign lverr_o = q.lverr;
    assign req_o   = q.req;

    // R3: the command is a single-cycle pulse
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |=> !q.req);

    // R4: a command requires the unlock and write enable one cycle earlier
    p_req_needs_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |-> $past(armed_i && wren_i));

    // R6: busy holds until the array reports done
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && !arr_done_i |=> q.busy);

    // R8: no command leaves for a protected address
    p_no_prot_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |-> !in_prot);

    // R9: low voltage during an operation is recorded
    p_lowvolt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && low_volt_i |=> q.lverr);

endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
    import nvm_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PAGE_BITS = 6,
    parameter logic [ADDR_W-1:0] PROT_LO = 'hF000,
    parameter logic [ADDR_W-1:0] PROT_HI = 'hFEFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data,
    output logic              arr_req,
    output logic [3:0]        arr_op,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic              arr_done,
    input  logic              low_volt
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_BITS;

    typedef struct packed {
        logic [3:0]        op;
        logic              wren;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t d, q;

    logic [1:0] idx, al;
    logic       wr_any, key_wr, other_wr, start_try;
    logic       armed, busy, wrerr, lverr;
    logic [ADDR_W-1:0] eff_addr;

    assign idx       = reg_addr[3:2];
    assign al        = reg_addr[1:0];
    assign wr_any    = reg_we && (al != AL_NONE);
    assign key_wr    = wr_any && (idx == IDX_KEY) && (al == AL_DIRECT);
    assign other_wr  = wr_any && !key_wr;
    assign start_try = wr_any && (idx == IDX_CTRL) && (al != AL_CLEAR) && reg_wdata[B_START];

    function automatic logic [ADDR_W-1:0] upd_a(logic [ADDR_W-1:0] o,
                                                logic [ADDR_W-1:0] w, logic [1:0] a);
        case (a)
            AL_DIRECT: return w;
            AL_SET:    return o | w;
            AL_CLEAR:  return o & ~w;
            default:   return o;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] upd_d(logic [DATA_W-1:0] o,
                                                logic [DATA_W-1:0] w, logic [1:0] a);
        case (a)
            AL_DIRECT: return w;
            AL_SET:    return o | w;
            AL_CLEAR:  return o & ~w;
            default:   return o;
        endcase
    endfunction

    function automatic logic [4:0] upd_c(logic [4:0] o, logic [4:0] w, logic [1:0] a);
        case (a)
            AL_DIRECT: return w;
            AL_SET:    return o | w;
            AL_CLEAR:  return o & ~w;
            default:   return o;
        endcase
    endfunction

    always_comb begin
        logic [4:0] c_new;
        d     = q;
        c_new = upd_c({q.wren, q.op}, {reg_wdata[B_WREN], reg_wdata[3:0]}, al);
        if (wr_any) begin
            case (idx)
                IDX_CTRL: begin
                    d.wren = c_new[4];
                    if (!busy) d.op = c_new[3:0];
                end
                IDX_ADDR: if (!busy) d.addr = upd_a(q.addr, reg_wdata[ADDR_W-1:0], al);
                IDX_DATA: if (!busy) d.data = upd_d(q.data, reg_wdata[DATA_W-1:0], al);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign eff_addr = (q.op == OP_ERASE) ? (q.addr & PAGE_MASK) : q.addr;

    nvm_key_tracker u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (key_wr),
        .key_val_i  (reg_wdata),
        .other_wr_i (other_wr),
        .armed_o    (armed)
    );

    nvm_op_seq #(
        .ADDR_W  (ADDR_W),
        .PROT_LO (PROT_LO),
        .PROT_HI (PROT_HI)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_try_i (start_try),
        .armed_i     (armed),
        .wren_i      (q.wren),
        .op_i        (q.op),
        .eff_addr_i  (eff_addr),
        .arr_done_i  (arr_done),
        .low_volt_i  (low_volt),
        .busy_o      (busy),
        .wrerr_o     (wrerr),
        .lverr_o     (lverr),
        .req_o       (arr_req)
    );

    assign arr_op    = q.op;
    assign arr_addr  = eff_addr;
    assign arr_wdata = q.data;

    always_comb begin
        case (rd_sel)
            IDX_CTRL: rd_data = {16'h0, busy, q.wren, wrerr, lverr, 8'h0, q.op};
            IDX_ADDR: rd_data = 32'(q.addr);
            IDX_DATA: rd_data = 32'(q.data);
            default:  rd_data = 32'h0;
        endcase
    end

    // R7: operation fields stay frozen while the array works
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !arr_done |=> $stable(q.addr) && $stable(q.data) && $stable(q.op));

endmodule

// File: tb/nvm_prog_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_prog_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        arr_req;
    logic [3:0]  arr_op;
    logic [15:0] arr_addr;
    logic [31:0] arr_wdata;
    logic        arr_done = 1'b0;
    logic        low_volt = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nvm_prog_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_done(arr_done), .low_volt(low_volt)
    );

    // {alias, write data, expected address}
    localparam logic [33:0] VEC [5] = '{
        {2'd0, 16'h1234, 16'h1234},
        {2'd1, 16'h00F0, 16'h12F4},
        {2'd2, 16'h0204, 16'h10F0},
        {2'd3, 16'hFFFF, 16'h10F0},
        {2'd0, 16'hABCD, 16'hABCD}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [1:0] al, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {idx, al}; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        rd_sel = s;
        #0.1;
        v = rd_data;
    endtask

    task automatic unlock();
        wr(2'd1, 2'd0, 32'h0000_0000);
        wr(2'd1, 2'd0, 32'hAA99_6655);
        wr(2'd1, 2'd0, 32'h5566_99AA);
    endtask

    task automatic start();
        wr(2'd0, 2'd1, 32'h0000_8000);
    endtask

    task automatic done();
        @(negedge clk); arr_done = 1'b1;
        @(negedge clk); arr_done = 1'b0;
    endtask

    task automatic nop_clear();
        wr(2'd0, 2'd0, 32'h0000_4000);
        unlock();
        start();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(2'd2, v); chk("R1 addr", v, 32'h0);
        rd(2'd3, v); chk("R1 data", v, 32'h0);
        chk("R1 req", 32'(arr_req), 32'h0);

        // R2 alias table on the address register
        for (int i = 0; i < 5; i++) begin
            wr(2'd2, VEC[i][33:32], {16'h0, VEC[i][31:16]});
            rd(2'd2, v); chk("R2 addr alias", v, {16'h0, VEC[i][15:0]});
        end
        wr(2'd1, 2'd0, 32'hAA99_6655);
        rd(2'd1, v); chk("R2 key reads zero", v, 32'h0);

        // R3 word write through full unlock
        wr(2'd2, 2'd0, 32'h0100);
        wr(2'd3, 2'd0, 32'hDEAD_BEEF);
        wr(2'd0, 2'd0, 32'h4001);
        unlock();
        start();
        chk("R3 req", 32'(arr_req), 32'h1);
        chk("R3 op", 32'(arr_op), 32'h1);
        chk("R11 word addr full", 32'(arr_addr), 32'h0100);
        chk("R3 wdata", arr_wdata, 32'hDEAD_BEEF);
        rd(2'd0, v); chk("R6 busy set", v, 32'hC001);
        wr(2'd0, 2'd2, 32'h8000);
        chk("R3 req single cycle", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R6 busy not clearable", v, 32'hC001);
        wr(2'd2, 2'd0, 32'h5555);
        rd(2'd2, v); chk("R7 addr frozen", v, 32'h0100);
        wr(2'd3, 2'd0, 32'h1111_2222);
        rd(2'd3, v); chk("R7 data frozen", v, 32'hDEAD_BEEF);
        wr(2'd0, 2'd1, 32'h0004);
        rd(2'd0, v); chk("R7 op frozen", v, 32'hC001);
        done();
        rd(2'd0, v); chk("R6 busy cleared", v, 32'h4001);
        wr(2'd0, 2'd2, 32'h4000);
        rd(2'd0, v); chk("R2 clear wren", v, 32'h0001);

        // R4 no unlock
        wr(2'd0, 2'd1, 32'h4000);
        start();
        chk("R4 no req", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R4 wrerr", v, 32'h6001);

        // R10 nop clears, flags not writable
        nop_clear();
        chk("R10 no req", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R10 cleared", v, 32'h4000);
        wr(2'd0, 2'd1, 32'h3000);
        rd(2'd0, v); chk("R10 flags not writable", v, 32'h4000);

        // R5 keys out of order
        wr(2'd0, 2'd0, 32'h4001);
        wr(2'd1, 2'd0, 32'h0);
        wr(2'd1, 2'd0, 32'h5566_99AA);
        wr(2'd1, 2'd0, 32'hAA99_6655);
        start();
        chk("R5 order no req", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R5 order wrerr", v, 32'h6001);
        nop_clear();

        // R5 stray write between key and start
        wr(2'd0, 2'd0, 32'h4001);
        unlock();
        wr(2'd2, 2'd0, 32'h0200);
        start();
        chk("R5 stray no req", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R5 stray wrerr", v, 32'h6001);
        nop_clear();

        // R4 write enable low
        wr(2'd0, 2'd0, 32'h0001);
        unlock();
        start();
        chk("R4 wren low no req", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R4 wren low wrerr", v, 32'h2001);
        nop_clear();

        // R5 unlock consumed by one start
        wr(2'd0, 2'd0, 32'h4001);
        unlock();
        start();
        chk("R5 first start req", 32'(arr_req), 32'h1);
        done();
        start();
        chk("R5 reuse no req", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R5 reuse wrerr", v, 32'h6001);
        nop_clear();

        // R8 protected window
        wr(2'd2, 2'd0, 32'hF010);
        wr(2'd0, 2'd0, 32'h4001);
        unlock();
        start();
        chk("R8 no req", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R8 wrerr", v, 32'h6001);
        nop_clear();

        // R11 page erase, then R9 with coincident done and address write
        wr(2'd2, 2'd0, 32'h1237);
        wr(2'd0, 2'd0, 32'h4004);
        unlock();
        start();
        chk("R11 erase req", 32'(arr_req), 32'h1);
        chk("R11 erase op", 32'(arr_op), 32'h4);
        chk("R11 erase addr aligned", 32'(arr_addr), 32'h1200);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'b1000; reg_wdata = 32'h7777;
        arr_done = 1'b1; low_volt = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; arr_done = 1'b0; low_volt = 1'b0;
        rd(2'd0, v); chk("R9 lverr and done", v, 32'h5004);
        rd(2'd2, v); chk("R7 addr write on done cycle", v, 32'h1237);
        nop_clear();
        rd(2'd0, v); chk("R10 lverr cleared", v, 32'h4000);

        // R12 unsupported operation code
        wr(2'd0, 2'd0, 32'h4002);
        unlock();
        start();
        chk("R12 no req", 32'(arr_req), 32'h0);
        rd(2'd0, v); chk("R12 wrerr", v, 32'h6002);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule